// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects three interrupt sources from a graphics engine and presents them to the host as one registered interrupt request line. Two of the sources, the end of a binning pass and the end of a rendered frame, arrive as one-cycle pulses and are latched into a pending register. The third source reports that the binner has run out of memory. It is a level, and its pending bit stays set for as long as the condition input is high.

Software reads the pending register and acknowledges bits by writing ones to them. The enable mask is never written directly. One address turns enable bits on and a second address turns them off, and zero bits written to either address change nothing. Reading either of these two addresses returns the same current mask. A pending bit is recorded whether or not its source is enabled, so an enable written later raises the request at once. After reset nothing is pending and nothing is enabled. The driver normally enables the out-of-memory source first, because with no overflow memory supplied it is the only source that can fire at that point.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset the pending register reads 0, both enable addresses read 0, and `irq_o` is low.
- R2: A high pulse on `flush_done_i` or `frame_done_i`, sampled at a clock edge, sets pending bit 1 or bit 2 respectively from that edge on. The bit then stays set until it is cleared.
- R3: A write to word address 0 clears every pending bit whose written bit is 1. Bits written as 0 keep their state.
- R4: Pending bit 0 is set at every edge where `oom_level_i` is high, even when a clear of that bit is written at the same edge. Once the input is low, a clear removes the bit.
- R5: A write to word address 1 sets every enable bit whose written bit is 1. Bits written as 0 keep their state.
- R6: A write to word address 2 clears every enable bit whose written bit is 1. Bits written as 0 keep their state.
- R7: A read of word address 1 and a read of word address 2 both return the enable mask in bits [2:0].
- R8: `irq_o` is registered. It is high one edge after an edge at which (pending AND enable) is non-zero, and it is low otherwise.
- R9: When a clear of a pending bit and a new event for the same bit arrive at the same edge, the bit remains set.
- R10: Pending bits latch regardless of the enable mask. Enabling a source that is already pending raises `irq_o` one edge after the enable write takes effect.
- R11: Bits [31:3] of every read are 0, and a read of word address 3 returns 0. A write to word address 3 changes neither the pending bits nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address: 0 pending, 1 enable-set, 2 enable-clear |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| flush_done_i | input | 1 | Binning flush done event pulse |
| frame_done_i | input | 1 | Render frame done event pulse |
| oom_level_i | input | 1 | Binner out-of-memory condition level |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Read data is combinational, so a read reflects all writes and events sampled up to the previous edge. The bench checks it shortly after it drives the address, away from any edge. Pending bits and enables change at the edge that samples the write or the event. `irq_o` follows one edge later, so it trails a new pending bit by two edges from the stimulus. The bench model advances after each edge in the same order as the design: it computes the request from the old pending and enable state, then updates both. Each check compares the design with the model value for that cycle, which keeps every check on the right cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 2;

  // bit positions of the sources
  localparam int unsigned SRC_OOM   = 0;
  localparam int unsigned SRC_FLUSH = 1;
  localparam int unsigned SRC_FRAME = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_PEND   = 2'd0,
    A_EN_SET = 2'd1,
    A_EN_CLR = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irqc_status_bit.sv
module irqc_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic stat_o
);
  logic stat_q;
  logic stat_d;
  logic stat_ce;

  always_comb begin
    stat_ce = evt_i | clr_i;
    // an event wins over a simultaneous clear
    stat_d  = evt_i | (stat_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (stat_ce) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  p_evt_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> stat_o);
  p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> !stat_o);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !evt_i) |=> $stable(stat_o));
endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] en_d;
  logic         en_ce;

  always_comb begin
    en_ce = (|set_i) | (|clr_i);
    en_d  = (en_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[i] && !clr_i[i]) |=> en_o[i]);
    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[i] |=> !en_o[i]);
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !clr_i[i]) |=> $stable(en_o[i]));
  end
endmodule

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode
  import irqc_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] stat_clr_o,
  output logic [NUM_SRC-1:0] en_set_o,
  output logic [NUM_SRC-1:0] en_clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] wbits;
  reg_addr_e          sel;

  always_comb begin
    wbits      = wdata_i[NUM_SRC-1:0];
    sel        = reg_addr_e'(addr_i);
    stat_clr_o = '0;
    en_set_o   = '0;
    en_clr_o   = '0;
    if (we_i) begin
      unique case (sel)
        A_PEND:   stat_clr_o = wbits;
        A_EN_SET: en_set_o   = wbits;
        A_EN_CLR: en_clr_o   = wbits;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      A_PEND:             rdata_o = {{PAD_W{1'b0}}, stat_i};
      A_EN_SET, A_EN_CLR: rdata_o = {{PAD_W{1'b0}}, en_i};
      default:            rdata_o = '0;
    endcase
  end

  always_comb begin
    a_one_target_r11: assert ($countones({|stat_clr_o, |en_set_o, |en_clr_o}) <= 1);
  end
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flush_done_i,
  input  logic              frame_done_i,
  input  logic              oom_level_i,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] stat;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] stat_clr;
  logic [NUM_SRC-1:0] en_set;
  logic [NUM_SRC-1:0] en_clr;
  logic               irq_d;
  logic               irq_q;

  always_comb begin
    evt            = '0;
    evt[SRC_OOM]   = oom_level_i;
    evt[SRC_FLUSH] = flush_done_i;
    evt[SRC_FRAME] = frame_done_i;
  end

  irqc_bus_decode u_dec (
    .addr_i     (bus_addr),
    .we_i       (bus_we),
    .wdata_i    (bus_wdata),
    .stat_i     (stat),
    .en_i       (en),
    .stat_clr_o (stat_clr),
    .en_set_o   (en_set),
    .en_clr_o   (en_clr),
    .rdata_o    (bus_rdata)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irqc_status_bit u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt[i]),
      .clr_i  (stat_clr[i]),
      .stat_o (stat[i])
    );
  end

  irqc_enable_reg #(.W(NUM_SRC)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (en_set),
    .clr_i (en_clr),
    .en_o  (en)
  );

  always_comb irq_d = |(stat & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & en)) |=> irq_o);
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & en)) |=> !irq_o);
  p_oom_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oom_level_i |=> stat[SRC_OOM]);
endmodule

// File: tb/gfx_irq_ctrl_tb.sv
module gfx_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        flush_done_i, frame_done_i, oom_level_i;
  logic        irq_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  int unsigned cyc   = 0;
  bit          done  = 0;

  logic [2:0] m_stat, m_en;
  logic       m_irq;

  always #10 clk = ~clk;  // 50 MHz

  gfx_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flush_done_i(flush_done_i), .frame_done_i(frame_done_i),
    .oom_level_i(oom_level_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] a,
                                           input logic [2:0] s,
                                           input logic [2:0] e);
    case (a)
      2'd0:       return {29'd0, s};
      2'd1, 2'd2: return {29'd0, e};
      default:    return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one bus cycle: drive at negedge, check, step model after the edge
  task automatic step(input string tag, input logic [1:0] a, input logic we,
                      input logic [31:0] wd, input logic fl, input logic fr,
                      input logic oom);
    logic [2:0] wb, ev;
    @(negedge clk);
    cyc++;
    check({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
    bus_addr = a; bus_we = we; bus_wdata = wd;
    flush_done_i = fl; frame_done_i = fr; oom_level_i = oom;
    #2;
    check({tag, " rd"}, bus_rdata, exp_read(a, m_stat, m_en));
    @(posedge clk);
    #1;
    wb    = wd[2:0];
    ev    = {fr, fl, oom};
    m_irq = |(m_stat & m_en);
    m_stat = ev | (m_stat & ~((we && a == 2'd0) ? wb : 3'b000));
    if (we && a == 2'd1) m_en = m_en | wb;
    if (we && a == 2'd2) m_en = m_en & ~wb;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      if (cyc > 150000 || $time > 64'd4000000) begin
        n_err++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin : main
    int unsigned r;
    r = $urandom(32'd20240611);
    m_stat = '0; m_en = '0; m_irq = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    flush_done_i = 0; frame_done_i = 0; oom_level_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step("R1 pend",  2'd0, 0, 0, 0, 0, 0);
    step("R1 enset", 2'd1, 0, 0, 0, 0, 0);
    step("R1 enclr", 2'd2, 0, 0, 0, 0, 0);
    // R10 latch while disabled, then R2 hold
    step("R10 flush", 2'd0, 0, 0, 1, 0, 0);
    step("R2 hold",   2'd0, 0, 0, 0, 0, 0);
    step("R2 frame",  2'd0, 0, 0, 0, 1, 0);
    step("R2 both",   2'd0, 0, 0, 0, 0, 0);
    // R5 set only bit 1, zeros ignored
    step("R5 set1",   2'd1, 1, 32'h2, 0, 0, 0);
    step("R10 irq",   2'd1, 0, 0, 0, 0, 0);
    step("R8 irq",    2'd2, 0, 0, 0, 0, 0);
    // R3 clear bit 1 only
    step("R3 clr1",   2'd0, 1, 32'h2, 0, 0, 0);
    step("R3 keep2",  2'd0, 0, 0, 0, 0, 0);
    step("R8 drop",   2'd0, 0, 0, 0, 0, 0);
    // R9 clear and event together
    step("R9 race",   2'd0, 1, 32'h4, 0, 1, 0);
    step("R9 kept",   2'd0, 0, 0, 0, 0, 0);
    // R4 level source
    step("R4 oom",    2'd1, 1, 32'h1, 0, 0, 1);
    step("R4 clrhi",  2'd0, 1, 32'h1, 0, 0, 1);
    step("R4 still",  2'd0, 0, 0, 0, 0, 1);
    step("R4 irq",    2'd0, 0, 0, 0, 0, 0);
    step("R4 clrlo",  2'd0, 1, 32'h1, 0, 0, 0);
    step("R4 gone",   2'd0, 0, 0, 0, 0, 0);
    // R11 unmapped address
    step("R11 wr3",   2'd3, 1, 32'hFFFF_FFFF, 0, 0, 0);
    step("R11 rd3",   2'd3, 0, 0, 0, 0, 0);
    step("R11 pend",  2'd0, 1, 32'hFFFF_FFF8, 0, 0, 0);
    // R6 clear enable bit 0, R7 mirror
    step("R6 clr0",   2'd2, 1, 32'h1, 0, 0, 0);
    step("R7 viaset", 2'd1, 0, 0, 0, 0, 0);
    step("R7 viaclr", 2'd2, 0, 0, 0, 0, 0);
    step("R6 clrall", 2'd2, 1, 32'hFFFF_FFFF, 0, 0, 0);
    step("R6 empty",  2'd1, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  a;
      logic        we, fl, fr, oom;
      logic [31:0] wd;
      a   = 2'($urandom_range(0, 3));
      we  = ($urandom_range(0, 2) == 0);
      wd  = $urandom;
      fl  = ($urandom_range(0, 9) == 0);
      fr  = ($urandom_range(0, 9) == 0);
      oom = ($urandom_range(0, 5) == 0);
      step("RAND", a, we, wd, fl, fr, oom);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule